// File: doc/BRIEF.md
# Serial Status Register with Read-Then-Clear Flags

This block holds the 8-bit status word of a serial communication port. The transmitter and receiver report events through one-cycle strobes and level signals, and the CPU reaches the word over a simple read/write bus. Five event flags are sticky. The CPU cannot set them. To clear one, the CPU must first see that flag at 1 in a read, then write 0 to its bit. This stops software from dropping an event it has never observed.

The remaining three bits behave differently. Two are read-only mirrors of transmitter and receiver levels. The lowest bit is an ordinary control bit that the CPU can read and write. An active-low reset loads the word with 0x84, and so does a standby request. The five sticky flags are also brought out as a vector so that interrupt logic can use them.

Top module: `sci_status_reg`

## Requirements
- R1: While `rst_n` is low, `cpu_rdata_o` reads 0x84 and `flags_o` reads 5'b10000, whatever the other inputs are.
- R2: When `standby_i` is high at a clock edge, the word becomes 0x84 after that edge. Any read-arming gathered earlier is discarded, so an unread flag must be read again before a write of 0 can clear it.
- R3: A CPU write never sets bits 7..3. A written 1 leaves the bit as it was.
- R4: A write of 0 to one of bits 7..3 clears that flag only if a read returned it as 1 at an earlier edge since it last became set. Otherwise the flag stays at 1.
- R5: `flag_set_i[k]` sets status bit 3+k one edge later. The mapping is: [4] transmit-buffer-empty (bit 7), [3] receive-full (bit 6), [2] overrun (bit 5), [1] framing error (bit 4), [0] parity error (bit 3).
- R6: If a set strobe and an armed clear hit the same flag in one cycle, the flag stays 1 and becomes unarmed. A following write of 0 without a new read leaves it set.
- R7: Bit 2 shows `tx_end_i` and bit 1 shows `rx_mpb_i`, each registered once. CPU writes have no effect on either bit.
- R8: Every CPU write loads bit 0 from `cpu_wdata_i[0]`, and reads return it.
- R9: `flags_o` carries status bits 7..3 in the same order.
- R10: A read arms only the flags that are 1 at that read. Arming persists through writes of 1, so a later write can clear a subset of the armed flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry; reloads the reset value |
| cpu_rd_i | input | 1 | CPU read strobe for this cycle |
| cpu_wr_i | input | 1 | CPU write strobe for this cycle |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Current status word |
| flag_set_i | input | 5 | Hardware set strobes for bits 7..3 |
| tx_end_i | input | 1 | Transmit-end level |
| rx_mpb_i | input | 1 | Received multiprocessor bit level |
| flags_o | output | 5 | Sticky flags for interrupt logic |

## Verification
Every registered effect (set strobes, clears, arming, standby, the mirrored levels and the control bit) reaches `cpu_rdata_o` exactly one rising edge after the cycle that applies it. The read port itself is combinational. The bench therefore drives each stimulus at a falling edge and compares one nanosecond after the next rising edge, before any new input changes. Arming is a hidden state, so it is checked through its effect on later writes. The reset value is compared while reset is still held.

// File: rtl/sci_status_pkg.sv
package sci_status_pkg;

    // Per-flag state: the sticky flag and whether a read has seen it set
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;

    // Non-sticky low bits of the status word
    typedef struct packed {
        logic tend;
        logic mpb;
        logic mpbt;
    } aux_state_t;

    localparam int unsigned LOW_BITS = 3;

endpackage

// File: rtl/sci_flag_cell.sv
module sci_flag_cell
    import sci_status_pkg::*;
#(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (standby_i) begin
            st_d.flag  = INIT;
            st_d.armed = 1'b0;
        end else if (set_i) begin
            // a new event always wins and needs a fresh read
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (wr_i && !wbit_i && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag  <= INIT;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/sci_aux_bits.sv
module sci_aux_bits
    import sci_status_pkg::*;
#(
    parameter logic TEND_INIT = 1'b1,
    parameter logic MPB_INIT  = 1'b0,
    parameter logic MPBT_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic tx_end_i,
    input  logic rx_mpb_i,
    input  logic wr_i,
    input  logic wbit0_i,
    output logic tend_o,
    output logic mpb_o,
    output logic mpbt_o
);

    aux_state_t aux_d, aux_q;

    always_comb begin
        aux_d = aux_q;
        if (standby_i) begin
            aux_d.tend = TEND_INIT;
            aux_d.mpb  = MPB_INIT;
            aux_d.mpbt = MPBT_INIT;
        end else begin
            aux_d.tend = tx_end_i;
            aux_d.mpb  = rx_mpb_i;
            if (wr_i) begin
                aux_d.mpbt = wbit0_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q.tend <= TEND_INIT;
            aux_q.mpb  <= MPB_INIT;
            aux_q.mpbt <= MPBT_INIT;
        end else begin
            aux_q <= aux_d;
        end
    end

    assign tend_o = aux_q.tend;
    assign mpb_o  = aux_q.mpb;
    assign mpbt_o = aux_q.mpbt;

endmodule

// File: rtl/sci_status_reg.sv
module sci_status_reg
    import sci_status_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h84
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           standby_i,
    input  logic                           cpu_rd_i,
    input  logic                           cpu_wr_i,
    input  logic [DATA_W-1:0]              cpu_wdata_i,
    output logic [DATA_W-1:0]              cpu_rdata_o,
    input  logic [DATA_W-LOW_BITS-1:0]     flag_set_i,
    input  logic                           tx_end_i,
    input  logic                           rx_mpb_i,
    output logic [DATA_W-LOW_BITS-1:0]     flags_o
);

    localparam int NFLAG = DATA_W - LOW_BITS;

    logic [NFLAG-1:0] flag_vec;
    logic             tend, mpb, mpbt;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sci_flag_cell #(
            .INIT (RESET_VAL[LOW_BITS+g])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby_i (standby_i),
            .set_i     (flag_set_i[g]),
            .rd_i      (cpu_rd_i),
            .wr_i      (cpu_wr_i),
            .wbit_i    (cpu_wdata_i[LOW_BITS+g]),
            .flag_o    (flag_vec[g])
        );
    end

    sci_aux_bits #(
        .TEND_INIT (RESET_VAL[2]),
        .MPB_INIT  (RESET_VAL[1]),
        .MPBT_INIT (RESET_VAL[0])
    ) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .tx_end_i  (tx_end_i),
        .rx_mpb_i  (rx_mpb_i),
        .wr_i      (cpu_wr_i),
        .wbit0_i   (cpu_wdata_i[0]),
        .tend_o    (tend),
        .mpb_o     (mpb),
        .mpbt_o    (mpbt)
    );

    assign cpu_rdata_o = {flag_vec, tend, mpb, mpbt};
    assign flags_o     = flag_vec;

endmodule

// File: rtl/sci_status_checker.sv
module sci_status_checker #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h84
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic              cpu_rd_i,
    input logic              cpu_wr_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic [DATA_W-1:0] cpu_rdata_o,
    input logic [DATA_W-4:0] flag_set_i,
    input logic              tx_end_i,
    input logic              rx_mpb_i,
    input logic [DATA_W-4:0] flags_o
);

    localparam int NF = DATA_W - 3;

    // Independent record of which flags a read has observed as set
    logic [NF-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = '0;
        if (!standby_i) begin
            seen_d = ~flag_set_i & flags_o & (seen_q | {NF{cpu_rd_i}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    AST_STANDBY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> cpu_rdata_o == RESET_VAL); // R2

    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && flag_set_i == '0) |=> ((flags_o & ~$past(flags_o)) == '0)); // R3

    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !standby_i)
        |=> (($past(cpu_wdata_i[DATA_W-1:3]) & $past(flags_o) & ~flags_o) == '0)); // R3

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> (($past(flags_o) & ~flags_o & ~$past(seen_q)) == '0)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && flag_set_i != '0)
        |=> ((flags_o & $past(flag_set_i)) == $past(flag_set_i))); // R6

    AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && cpu_wr_i && (cpu_wdata_i[2:1] != {tx_end_i, rx_mpb_i}))
        |=> cpu_rdata_o[2:1] == $past({tx_end_i, rx_mpb_i})); // R7

    AST_CTRL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !standby_i) |=> cpu_rdata_o[0] == $past(cpu_wdata_i[0])); // R8

endmodule

bind sci_status_reg sci_status_checker #(
    .DATA_W    (DATA_W),
    .RESET_VAL (RESET_VAL)
) u_chk (.*);

// File: tb/sci_status_reg_test.sv
`timescale 1ns/100ps
module sci_status_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0;
    logic       cpu_rd_i = 1'b0;
    logic       cpu_wr_i = 1'b0;
    logic [7:0] cpu_wdata_i = 8'h00;
    logic [7:0] cpu_rdata_o;
    logic [4:0] flag_set_i = 5'b0;
    logic       tx_end_i = 1'b0;
    logic       rx_mpb_i = 1'b0;
    logic [4:0] flags_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sci_status_reg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .cpu_rd_i    (cpu_rd_i),
        .cpu_wr_i    (cpu_wr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_rdata_o (cpu_rdata_o),
        .flag_set_i  (flag_set_i),
        .tx_end_i    (tx_end_i),
        .rx_mpb_i    (rx_mpb_i),
        .flags_o     (flags_o)
    );

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [7:0] wdata;
        logic [4:0] set;
        logic       txend;
        logic       rxmpb;
        logic       stby;
        logic [7:0] expect_word;
        logic [3:0] req;
    } vec_t;

    // Flag bits: [4]=tx empty(b7) [3]=rx full(b6) [2]=overrun(b5) [1]=framing(b4) [0]=parity(b3)
    localparam vec_t VEC [0:14] = '{
        '{1'b0, 1'b1, 8'h00, 5'b00000, 1'b1, 1'b0, 1'b0, 8'h84, 4'd4 },  // R4 unread clear ignored
        '{1'b1, 1'b0, 8'h00, 5'b00000, 1'b1, 1'b0, 1'b0, 8'h84, 4'd10},  // R10 read arms b7
        '{1'b0, 1'b1, 8'h7F, 5'b00000, 1'b1, 1'b0, 1'b0, 8'h05, 4'd4 },  // R4 armed clear, R8 b0
        '{1'b0, 1'b0, 8'h00, 5'b01111, 1'b0, 1'b1, 1'b0, 8'h7B, 4'd5 },  // R5 four sets, R7 levels
        '{1'b0, 1'b1, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h7A, 4'd4 },  // R4 unread, R8 b0 -> 0
        '{1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h7A, 4'd10},  // R10 read arms b6..b3
        '{1'b0, 1'b1, 8'hBE, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h3A, 4'd10},  // R10 clear subset only
        '{1'b0, 1'b1, 8'h00, 5'b00100, 1'b0, 1'b1, 1'b0, 8'h22, 4'd6 },  // R6 set beats clear
        '{1'b0, 1'b1, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h22, 4'd6 },  // R6 disarmed by set
        '{1'b1, 1'b1, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h22, 4'd6 },  // R6 same-cycle read too late
        '{1'b0, 1'b1, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b0, 8'h02, 4'd4 },  // R4 now clears
        '{1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 1'b0, 1'b0, 8'h04, 4'd7 },  // R7 levels follow
        '{1'b0, 1'b1, 8'hFF, 5'b00000, 1'b1, 1'b0, 1'b0, 8'h05, 4'd3 },  // R3 ones set nothing
        '{1'b0, 1'b0, 8'h00, 5'b10000, 1'b1, 1'b0, 1'b0, 8'h85, 4'd5 },  // R5 tx empty set
        '{1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 1'b0, 1'b1, 8'h84, 4'd2 }   // R2 standby reload
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [7:0] wd,
                        input logic [4:0] st, input logic te, input logic mp,
                        input logic sb);
        @(negedge clk);
        cpu_rd_i    = rd;
        cpu_wr_i    = wr;
        cpu_wdata_i = wd;
        flag_set_i  = st;
        tx_end_i    = te;
        rx_mpb_i    = mp;
        standby_i   = sb;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // R1 reset value held during reset
        repeat (3) @(posedge clk);
        #1;
        check(1, cpu_rdata_o, 8'h84);
        check(1, {3'b0, flags_o}, 8'h10);
        @(negedge clk);
        tx_end_i = 1'b1;
        rst_n    = 1'b1;

        for (int i = 0; i < 15; i++) begin
            step(VEC[i].rd, VEC[i].wr, VEC[i].wdata, VEC[i].set,
                 VEC[i].txend, VEC[i].rxmpb, VEC[i].stby);
            check(int'(VEC[i].req), cpu_rdata_o, VEC[i].expect_word);
        end

        // R2 arming from before standby is discarded
        step(1'b1, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        check(2, cpu_rdata_o, 8'h84);

        // R9 flag vector mirrors bits 7..3
        step(1'b0, 1'b0, 8'h00, 5'b11111, 1'b1, 1'b0, 1'b0);
        check(9, {3'b0, flags_o}, 8'h1F);
        check(5, cpu_rdata_o, 8'hFC);

        // R10 a read arms only flags that are 1 at that moment
        step(1'b0, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h00, 5'b01000, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        check(10, cpu_rdata_o, 8'h44);
        check(9, {3'b0, flags_o}, 8'h08);

        // R1 reset asserted mid-run
        @(negedge clk);
        cpu_wr_i = 1'b0;
        tx_end_i = 1'b0;
        rx_mpb_i = 1'b1;
        rst_n    = 1'b0;
        #1;
        check(1, cpu_rdata_o, 8'h84);
        check(1, {3'b0, flags_o}, 8'h10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule